// File: doc/BRIEF.md
# Slot Reset and Power-Up Sequencer

This block brings an add-in card slot out of reset in a fixed order. It has three outputs it must order: an active-low reset line to the board, a reset bit for the local link controller (0 holds the controller in reset, 1 releases it) and an enable for the slot power supply. A start pulse drives both resets into the asserted state. Power is enabled on the next cycle, and then both resets are held for a settling window of at least 100 ms. After that window the controller bit is released first, the board line one cycle later, and a done flag rises one cycle after that.

The settling window is a cycle count. It is derived from a clock-frequency parameter and a millisecond parameter, so a simulation can use a small clock figure to shorten it. A shutdown pulse puts both resets back into the asserted state at any time. It leaves the power enable where it is, so that a later boot finds the link down. A start that arrives while a sequence is in flight has no effect. A start that arrives once the sequence has finished runs the whole sequence again.

Top module: `slot_reset_sequencer`

## Requirements
- R1: While the system reset is asserted, and in the first cycle after it is released, the power enable, the controller reset bit, the board reset line and the done flag are all 0.
- R2: A start pulse taken while idle or finished drives the board line to 0, the controller bit to 0 and the done flag to 0 at the next clock edge.
- R3: The power enable goes to 1 one cycle after a start is taken. When it rises, both resets are still asserted (controller bit 0, board line 0).
- R4: The controller bit goes to 1 exactly HOLD cycles after the power-enable edge of the same sequence, where HOLD = (CLK_HZ / 1000) * HOLD_MS, with a minimum of 1. Until then it stays 0.
- R5: The board line goes to 1 exactly one cycle after the controller bit goes to 1.
- R6: The done flag goes to 1 exactly one cycle after the board line goes to 1.
- R7: A shutdown pulse drives the controller bit, the board line and the done flag to 0 at the next edge and leaves the power enable unchanged. Any sequence in flight is abandoned, so no release follows.
- R8: When start and shutdown arrive in the same cycle, shutdown wins: no sequence starts, and the power enable does not change.
- R9: A start pulse taken while a sequence is in flight (any state between the start being taken and the done flag rising) has no effect on any output or on the release timing.
- R10: A start pulse taken after done has risen runs the whole sequence again: the resets re-assert, and the controller bit is released HOLD cycles after the cycle in which power would be raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| shutdown_i | input | 1 | One-cycle request to re-assert both resets |
| slot_pwr_en_o | output | 1 | Slot power enable |
| ctrl_rst_n_o | output | 1 | Controller reset bit, 0 holds and 1 releases |
| board_rst_n_o | output | 1 | Active-low board reset line |
| seq_done_o | output | 1 | Sequence finished, both resets released |

## Verification
Start and shutdown can land in the same cycle, and the design must let the shutdown win. The bench provokes this right after a fresh system reset, while power is still off. If the start won, it would show at once as a rising power enable. So the outcome is judged by the power enable staying low on the next cycle and by no release appearing after a full hold window. A second overlap is a shutdown landing in the middle of a hold window; it is judged by the absence of the release at the cycle a finished hold would have produced.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_ASSERT  = 3'd1,
    SQ_HOLD    = 3'd2,
    SQ_CTRL_UP = 3'd3,
    SQ_PIN_UP  = 3'd4,
    SQ_READY   = 3'd5
  } sq_state_e;

  // One-cycle commands from the sequencer to the output bank
  typedef struct packed {
    logic drop_rst;
    logic raise_pwr;
    logic free_ctrl;
    logic free_pin;
    logic flag_done;
  } sq_cmd_t;

  // Settling window in clock cycles, never below one
  function automatic int unsigned calc_hold(input int unsigned hz, input int unsigned ms);
    int unsigned raw;
    raw = (hz / 1000) * ms;
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/slot_hold_timer.sv
module slot_hold_timer #(
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // next-state: load on power-up, count down while holding
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    shutdown_i,
  input  logic    expired_i,
  output sq_cmd_t cmd_o,
  output logic    hold_o
);

  sq_state_e st_q;
  sq_state_e st_d;
  sq_cmd_t   cmd;

  always_comb begin
    st_d = st_q;
    cmd  = '0;
    if (shutdown_i) begin
      // shutdown outranks everything, including a start in the same cycle
      cmd.drop_rst = 1'b1;
      st_d         = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE, SQ_READY: begin
          if (start_i) begin
            cmd.drop_rst = 1'b1;
            st_d         = SQ_ASSERT;
          end
        end
        SQ_ASSERT: begin
          cmd.raise_pwr = 1'b1;
          st_d          = SQ_HOLD;
        end
        SQ_HOLD: begin
          if (expired_i) begin
            cmd.free_ctrl = 1'b1;
            st_d          = SQ_CTRL_UP;
          end
        end
        SQ_CTRL_UP: begin
          cmd.free_pin = 1'b1;
          st_d         = SQ_PIN_UP;
        end
        SQ_PIN_UP: begin
          cmd.flag_done = 1'b1;
          st_d          = SQ_READY;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign cmd_o  = cmd;
  assign hold_o = (st_q == SQ_HOLD);

endmodule

// File: rtl/slot_out_bank.sv
module slot_out_bank
  import slot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sq_cmd_t cmd_i,
  output logic    pwr_en_o,
  output logic    ctrl_rst_n_o,
  output logic    board_rst_n_o,
  output logic    done_o
);

  logic pwr_q, ctrl_q, pin_q, done_q;
  logic pwr_en, ctrl_en, pin_en, done_en;
  logic pwr_d, ctrl_d, pin_d, done_d;

  // enables and data: a drop command forces 0, a release command forces 1
  always_comb begin
    pwr_en  = cmd_i.raise_pwr;
    pwr_d   = 1'b1;
    ctrl_en = cmd_i.drop_rst | cmd_i.free_ctrl;
    ctrl_d  = ~cmd_i.drop_rst;
    pin_en  = cmd_i.drop_rst | cmd_i.free_pin;
    pin_d   = ~cmd_i.drop_rst;
    done_en = cmd_i.drop_rst | cmd_i.flag_done;
    done_d  = ~cmd_i.drop_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      ctrl_q <= 1'b0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (pwr_en)  pwr_q  <= pwr_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (pin_en)  pin_q  <= pin_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign pwr_en_o      = pwr_q;
  assign ctrl_rst_n_o  = ctrl_q;
  assign board_rst_n_o = pin_q;
  assign done_o        = done_q;

endmodule

// File: rtl/slot_reset_sequencer.sv
module slot_reset_sequencer
  import slot_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned HOLD_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic shutdown_i,
  output logic slot_pwr_en_o,
  output logic ctrl_rst_n_o,
  output logic board_rst_n_o,
  output logic seq_done_o
);

  localparam int unsigned HOLD_CYC = calc_hold(CLK_HZ, HOLD_MS);

  sq_cmd_t cmd;
  logic    hold_run;
  logic    hold_expired;

  slot_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .shutdown_i (shutdown_i),
    .expired_i  (hold_expired),
    .cmd_o      (cmd),
    .hold_o     (hold_run)
  );

  slot_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cmd.raise_pwr),
    .run_i     (hold_run),
    .expired_o (hold_expired)
  );

  slot_out_bank u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_i         (cmd),
    .pwr_en_o      (slot_pwr_en_o),
    .ctrl_rst_n_o  (ctrl_rst_n_o),
    .board_rst_n_o (board_rst_n_o),
    .done_o        (seq_done_o)
  );

endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk
  import slot_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned HOLD_MS = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic shutdown_i,
  input logic slot_pwr_en_o,
  input logic ctrl_rst_n_o,
  input logic board_rst_n_o,
  input logic seq_done_o
);

  localparam int unsigned HOLD_CYC = calc_hold(CLK_HZ, HOLD_MS);
  localparam int unsigned AGE_W    = $clog2(HOLD_CYC + 1);

  // cycles the power enable has been high, saturating at the window length
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (!slot_pwr_en_o) begin
      age_q <= '0;
    end else if (age_q != AGE_W'(HOLD_CYC)) begin
      age_q <= age_q + AGE_W'(1);
    end
  end

  // R3
  pwr_after_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_pwr_en_o) |-> (!ctrl_rst_n_o && !board_rst_n_o));

  // R4
  ctrl_hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> (slot_pwr_en_o && (age_q == AGE_W'(HOLD_CYC))));

  // R5
  pin_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst_n_o) |-> ($past(ctrl_rst_n_o) && !$past(ctrl_rst_n_o, 2)));

  // R6
  done_after_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done_o) |-> ($past(board_rst_n_o) && !$past(board_rst_n_o, 2)));

  // R7
  shutdown_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (!ctrl_rst_n_o && !board_rst_n_o && !seq_done_o));

  // R7
  shutdown_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> $stable(slot_pwr_en_o));

  // R8
  shutdown_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && shutdown_i) |=> ($stable(slot_pwr_en_o) && !board_rst_n_o));

endmodule

bind slot_reset_sequencer slot_seq_chk #(
  .CLK_HZ  (CLK_HZ),
  .HOLD_MS (HOLD_MS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .shutdown_i    (shutdown_i),
  .slot_pwr_en_o (slot_pwr_en_o),
  .ctrl_rst_n_o  (ctrl_rst_n_o),
  .board_rst_n_o (board_rst_n_o),
  .seq_done_o    (seq_done_o)
);

// File: tb/sim_slot_reset_sequencer.sv
`timescale 1ns/1ps
module sim_slot_reset_sequencer;

  localparam int unsigned CLK_HZ  = 1000;
  localparam int unsigned HOLD_MS = 100;
  localparam int          N       = (CLK_HZ / 1000) * HOLD_MS;  // 100 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic shutdown = 1'b0;
  logic pwr, ctrl, pin, done;

  slot_reset_sequencer #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .shutdown_i    (shutdown),
    .slot_pwr_en_o (pwr),
    .ctrl_rst_n_o  (ctrl),
    .board_rst_n_o (pin),
    .seq_done_o    (done)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  // scoreboard: expected {pwr, ctrl, pin, done} at an absolute cycle
  int         q_at[$];
  logic [3:0] q_val[$];
  string      q_tag[$];

  task automatic expect_at(input int at, input logic [3:0] val, input string tag);
    int i;
    i = q_at.size();
    while (i > 0 && q_at[i-1] > at) i--;
    q_at.insert(i, at);
    q_val.insert(i, val);
    q_tag.insert(i, tag);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    #1;
    while (q_at.size() > 0 && q_at[0] <= cyc) begin
      n_chk++;
      if (q_at[0] < cyc) begin
        n_bad++;
        $display("FAIL %s: cycle %0d missed actual=none expected=%b", q_tag[0], q_at[0], q_val[0]);
      end else if ({pwr, ctrl, pin, done} !== q_val[0]) begin
        n_bad++;
        $display("FAIL %s: cycle %0d actual=%b expected=%b", q_tag[0], cyc, {pwr, ctrl, pin, done}, q_val[0]);
      end
      void'(q_at.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic step_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(input logic st, input logic sd);
    start = st;
    shutdown = sd;
    @(negedge clk);
    start = 1'b0;
    shutdown = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    expect_at(cyc + 1, 4'b0000, "R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(cyc + 1, 4'b0000, "R1");
    @(negedge clk);
  endtask

  // full sequence started at the current negedge; returns the first output cycle
  task automatic run_full(input string first_tag, input logic pwr_before, output int s);
    s = cyc + 1;
    expect_at(s,         {pwr_before, 3'b000}, first_tag);
    expect_at(s + 1,     4'b1000, "R3");
    expect_at(s + N,     4'b1000, "R4");
    expect_at(s + N + 1, 4'b1100, "R4");
    expect_at(s + N + 2, 4'b1110, "R5");
    expect_at(s + N + 3, 4'b1111, "R6");
    pulse(1'b1, 1'b0);
  endtask

  initial begin
    int s;
    @(negedge clk);
    do_reset();

    // first power-up from idle, with starts that must be ignored (R9)
    run_full("R2", 1'b0, s);
    step_to(s + 10);
    expect_at(s + 11, 4'b1000, "R9");
    pulse(1'b1, 1'b0);
    step_to(s + N + 1);
    expect_at(s + N + 2, 4'b1110, "R9");
    pulse(1'b1, 1'b0);
    step_to(s + N + 5);

    // restart from the finished state (R10)
    run_full("R10", 1'b1, s);
    expect_at(s + N + 1, 4'b1100, "R10");
    step_to(s + N + 5);

    // shutdown from the finished state keeps power, drops resets (R7)
    expect_at(cyc + 1, 4'b1000, "R7");
    expect_at(cyc + 5, 4'b1000, "R7");
    expect_at(cyc + N + 10, 4'b1000, "R7");
    pulse(1'b0, 1'b1);
    step_to(cyc + N + 12);

    // shutdown in the middle of the hold window abandons the sequence (R7)
    s = cyc + 1;
    expect_at(s, 4'b1000, "R2");
    pulse(1'b1, 1'b0);
    step_to(s + 20);
    expect_at(s + 21, 4'b1000, "R7");
    expect_at(s + N + 1, 4'b1000, "R7");
    expect_at(s + N + 3, 4'b1000, "R7");
    pulse(1'b0, 1'b1);
    step_to(s + N + 5);

    // fresh reset, then start and shutdown together: shutdown wins (R8)
    do_reset();
    s = cyc + 1;
    expect_at(s,         4'b0000, "R8");
    expect_at(s + 1,     4'b0000, "R8");
    expect_at(s + N + 3, 4'b0000, "R8");
    pulse(1'b1, 1'b1);
    step_to(s + N + 5);

    // the block still powers up normally afterwards
    run_full("R2", 1'b0, s);
    step_to(s + N + 5);

    while (q_at.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule